// File: doc/BRIEF.md
# RAMDAC Host Register Port

This block is the host-facing register port of a video RAMDAC. The host writes single bytes through eight directly addressed registers. The register address is formed from a bank-select bit and the two-bit byte lane of the access. Behind those registers sit two stores. The first is a colour palette that is loaded one component at a time and advances its write index by itself. The second is a byte-wide register file reached through a 16-bit indirect address.

Two settings are decoded from the register file. The pixel-clock PLL setting is checked for a legal source and unpacked into a prescale factor, a VCO divider and a reference divider. The pixel-format code says whether 8-bit indexed colour is selected, and that selection turns the display on. A pixel mask register is also held; any value other than all-ones raises a flag, because only a full mask is supported. The palette is read through a separate combinational port for the pixel path. Analog conversion is not part of this block.

Top module: `ramdac_regport`

## Requirements
- R1: An access with `wr_byte` low (a wider access) changes no register, palette entry or output, whatever the lane, bank and data.
- R2: The direct register number is {bank_sel, lane}, giving this map: 0 palette write index, 1 palette data, 2 pixel mask, 3 no effect, 4 index low byte, 5 index high byte, 6 index data, 7 no effect.
- R3: A write to register 0 loads the palette write index and returns the component counter to zero, so any partly gathered colour is dropped.
- R4: Register 1 writes are gathered as red, then green, then blue. The third write stores {red, green, blue} (red in bits 23:16) at the current index and advances the index by one.
- R5: The palette write index wraps from the last entry (255 by default) to 0.
- R6: Registers 4 and 5 form a 16-bit indirect address (high byte from register 5). A register 6 write stores the byte there when the address is below FILE_DEPTH and is dropped otherwise.
- R7: A register-file write to address 0x0002 with bit 0 set starts the PLL. If bits 1:0 of the PLL control byte at 0x0010 equal 1, `pll_ok` rises and `pll_src_err` falls. Otherwise `pll_src_err` rises and `pll_ok` falls. A write to 0x0002 with bit 0 clear changes neither.
- R8: On a PLL start with a legal source: `pll_m` = 8 >> F0[7:6]; `pll_vco_div` = F0[5:0] + 65; `pll_ref_div` = F1[4:0] * `pll_m`. F0 is the byte at 0x0020 and F1 the byte at 0x0021.
- R9: A register-file write to 0x000A with value 3 sets `disp_en` and clears `fmt_bad`. Any other value clears `disp_en` and sets `fmt_bad`.
- R10: `mask_partial` is high exactly when the pixel mask register holds a value other than 0xFF.
- R11: After reset, all palette entries read 0, the pixel mask is 0xFF, and `pll_ok`, `pll_src_err`, `disp_en`, `fmt_bad` and `mask_partial` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_byte | input | 1 | High when the access is byte-wide |
| bank_sel | input | 1 | Register bank select, upper bit of the register number |
| lane | input | 2 | Byte lane, lower bits of the register number |
| wr_data | input | 8 | Write data byte |
| pal_rd_idx | input | PAL_IW | Palette read index for the pixel path |
| pal_rd_rgb | output | 24 | Palette entry {red, green, blue} at `pal_rd_idx` |
| pll_ok | output | 1 | PLL started with a legal source |
| pll_src_err | output | 1 | Last PLL start found an illegal source |
| pll_m | output | 4 | Prescale factor |
| pll_vco_div | output | 8 | VCO divider |
| pll_ref_div | output | 8 | Reference divider |
| disp_en | output | 1 | 8-bit indexed format selected; display enabled |
| fmt_bad | output | 1 | Last pixel-format code was unsupported |
| mask_partial | output | 1 | Pixel mask is not all-ones |

## Verification
The bench builds the block with the default PAL_DEPTH of 256 and FILE_DEPTH of 256. With a full 8-bit palette index, a colour triple written at entry 255 followed by one more triple shows the wrap to entry 0. With a 256-byte register file, an indirect address of 0x010A lies beyond the file while sharing its low byte with the pixel-format address. A write there must be dropped and must leave the display enable unchanged. This separates full 16-bit address matching from matching on the low byte only.

// File: rtl/ramdac_pkg.sv
// ramdac_pkg: shared register numbers, indirect addresses and codes for the
// RAMDAC register port. Assumes 8-bit host data and a 16-bit indirect index.
package ramdac_pkg;

    // Direct register numbers, formed as {bank_sel, lane}
    typedef enum logic [2:0] {
        DR_PAL_WIDX  = 3'd0,
        DR_PAL_DATA  = 3'd1,
        DR_PIX_MASK  = 3'd2,
        DR_SPARE_LO  = 3'd3,
        DR_IDX_LO    = 3'd4,
        DR_IDX_HI    = 3'd5,
        DR_IDX_DATA  = 3'd6,
        DR_SPARE_HI  = 3'd7
    } dreg_e;

    localparam int unsigned NUM_DREG   = 8;
    localparam int unsigned IDX_W      = 16;

    // Indirect register-file addresses the mode decoder watches
    localparam logic [IDX_W-1:0] IX_CLK_CTRL = 16'h0002;
    localparam logic [IDX_W-1:0] IX_PIX_FMT  = 16'h000A;
    localparam logic [IDX_W-1:0] IX_PLL_SRC  = 16'h0010;
    localparam logic [IDX_W-1:0] IX_PLL_F0   = 16'h0020;
    localparam logic [IDX_W-1:0] IX_PLL_F1   = 16'h0021;

    localparam int unsigned  PLL_START_BIT = 0;
    localparam logic [1:0]   PLL_SRC_OK    = 2'd1;
    localparam logic [7:0]   FMT_INDEX8    = 8'd3;
    localparam logic [7:0]   VCO_BASE      = 8'd65;
    localparam logic [7:0]   MASK_FULL     = 8'hFF;

endpackage

// File: rtl/ramdac_port_decode.sv
// ramdac_port_decode: turns a host write into one-hot direct-register strobes.
// Assumes the register number is {bank_sel, lane}; wide accesses select nothing.
module ramdac_port_decode
    import ramdac_pkg::*;
#(
    parameter int unsigned NUM = NUM_DREG
) (
    input  logic           wr_en,
    input  logic           wr_byte,
    input  logic           bank_sel,
    input  logic [1:0]     lane,
    output logic [NUM-1:0] sel
);
    localparam int unsigned AW = $clog2(NUM);

    logic [AW-1:0] reg_num;
    logic          byte_hit;

    // Form the register number and qualify the access
    always_comb begin
        reg_num  = AW'({bank_sel, lane});
        byte_hit = wr_en & wr_byte;
    end

    // One comparator per direct register
    for (genvar i = 0; i < NUM; i++) begin : g_sel
        assign sel[i] = byte_hit && (reg_num == AW'(i));
    end

endmodule

// File: rtl/ramdac_palette.sv
// ramdac_palette: colour table loaded one component per write.
// Assumes ld_addr and wr_comp are never high together; DEPTH is at most 256.
module ramdac_palette #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          wr_comp,
    input  logic [7:0]    din,
    input  logic [IW-1:0] rd_idx,
    output logic [23:0]   rd_rgb,
    output logic [1:0]    phase
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [23:0]   mem [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [7:0]    red_q;
    logic [7:0]    grn_q;
    logic          commit;

    // The third component completes a triple
    always_comb commit = wr_comp && !ld_addr && (phase == 2'd2);

    // Write index, component counter and held components
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            phase  <= 2'd0;
            red_q  <= 8'd0;
            grn_q  <= 8'd0;
        end else if (ld_addr) begin
            wr_idx <= IW'(din);
            phase  <= 2'd0;
        end else if (wr_comp) begin
            case (phase)
                2'd0: begin
                    red_q <= din;
                    phase <= 2'd1;
                end
                2'd1: begin
                    grn_q <= din;
                    phase <= 2'd2;
                end
                default: begin
                    phase  <= 2'd0;
                    wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
                end
            endcase
        end
    end

    // Colour table storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= 24'd0;
        end else if (commit) begin
            mem[wr_idx] <= {red_q, grn_q, din};
        end
    end

    // Pixel-path read port
    always_comb rd_rgb = mem[rd_idx];

endmodule

// File: rtl/ramdac_index_file.sv
// ramdac_index_file: 16-bit indirect address and the byte register file.
// Assumes the watched PLL addresses lie below DEPTH; writes past DEPTH drop.
module ramdac_index_file
    import ramdac_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             st_data,
    input  logic [7:0]       din,
    output logic             ev_wr,
    output logic [IDX_W-1:0] ev_addr,
    output logic [7:0]       ev_val,
    output logic [1:0]       pll_src,
    output logic [7:0]       pll_f0,
    output logic [4:0]       pll_f1n
);
    localparam int unsigned FW = $clog2(DEPTH);

    logic [7:0]  file_q [DEPTH];
    logic [7:0]  idx_lo;
    logic [7:0]  idx_hi;
    logic        in_range;

    // Indirect address halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_lo <= 8'd0;
            idx_hi <= 8'd0;
        end else begin
            if (ld_lo) idx_lo <= din;
            if (ld_hi) idx_hi <= din;
        end
    end

    // Full address and range test
    always_comb begin
        ev_addr  = {idx_hi, idx_lo};
        in_range = ({16'd0, ev_addr} < 32'(DEPTH));
        ev_wr    = st_data;
        ev_val   = din;
    end

    // Register file storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) file_q[k] <= 8'd0;
        end else if (st_data && in_range) begin
            file_q[ev_addr[FW-1:0]] <= din;
        end
    end

    // Fields the PLL decoder reads
    always_comb begin
        pll_src = file_q[FW'(IX_PLL_SRC)][1:0];
        pll_f0  = file_q[FW'(IX_PLL_F0)];
        pll_f1n = file_q[FW'(IX_PLL_F1)][4:0];
    end

endmodule

// File: rtl/ramdac_mode_decode.sv
// ramdac_mode_decode: watches register-file writes and latches the PLL
// divider set and the pixel-format state. Assumes the file fields are current.
module ramdac_mode_decode
    import ramdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_wr,
    input  logic [IDX_W-1:0] ev_addr,
    input  logic [7:0]       ev_val,
    input  logic [1:0]       pll_src,
    input  logic [7:0]       pll_f0,
    input  logic [4:0]       pll_f1n,
    output logic             pll_ok,
    output logic             pll_src_err,
    output logic [3:0]       pll_m,
    output logic [7:0]       pll_vco_div,
    output logic [7:0]       pll_ref_div,
    output logic             fmt_ok,
    output logic             fmt_bad
);
    logic [3:0] m_calc;
    logic [7:0] vco_calc;
    logic [7:0] ref_calc;
    logic       pll_start;
    logic       fmt_write;

    // Divider arithmetic from the current file contents
    always_comb begin
        m_calc    = 4'd8 >> pll_f0[7:6];
        vco_calc  = {2'b00, pll_f0[5:0]} + VCO_BASE;
        ref_calc  = 8'({3'b000, pll_f1n} * {4'b0000, m_calc});
        pll_start = ev_wr && (ev_addr == IX_CLK_CTRL) && ev_val[PLL_START_BIT];
        fmt_write = ev_wr && (ev_addr == IX_PIX_FMT);
    end

    // PLL state latched on a start request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_ok      <= 1'b0;
            pll_src_err <= 1'b0;
            pll_m       <= 4'd0;
            pll_vco_div <= 8'd0;
            pll_ref_div <= 8'd0;
        end else if (pll_start) begin
            if (pll_src == PLL_SRC_OK) begin
                pll_ok      <= 1'b1;
                pll_src_err <= 1'b0;
                pll_m       <= m_calc;
                pll_vco_div <= vco_calc;
                pll_ref_div <= ref_calc;
            end else begin
                pll_ok      <= 1'b0;
                pll_src_err <= 1'b1;
            end
        end
    end

    // Pixel-format state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_ok  <= 1'b0;
            fmt_bad <= 1'b0;
        end else if (fmt_write) begin
            fmt_ok  <= (ev_val == FMT_INDEX8);
            fmt_bad <= (ev_val != FMT_INDEX8);
        end
    end

endmodule

// File: rtl/ramdac_regport.sv
// ramdac_regport: top of the RAMDAC host register port. Decodes byte writes
// to direct registers, feeds the palette and the indexed file, holds the pixel
// mask. Assumes one write per cycle and synchronous active-low reset.
module ramdac_regport
    import ramdac_pkg::*;
#(
    parameter int unsigned PAL_DEPTH  = 256,
    parameter int unsigned FILE_DEPTH = 256,
    localparam int unsigned PAL_IW    = $clog2(PAL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic              bank_sel,
    input  logic [1:0]        lane,
    input  logic [7:0]        wr_data,
    input  logic [PAL_IW-1:0] pal_rd_idx,
    output logic [23:0]       pal_rd_rgb,
    output logic              pll_ok,
    output logic              pll_src_err,
    output logic [3:0]        pll_m,
    output logic [7:0]        pll_vco_div,
    output logic [7:0]        pll_ref_div,
    output logic              disp_en,
    output logic              fmt_bad,
    output logic              mask_partial
);
    logic [NUM_DREG-1:0] sel;
    logic [1:0]          pal_phase;
    logic                ev_wr;
    logic [IDX_W-1:0]    ev_addr;
    logic [7:0]          ev_val;
    logic [1:0]          pll_src;
    logic [7:0]          pll_f0;
    logic [4:0]          pll_f1n;
    logic [7:0]          pix_mask;

    ramdac_port_decode #(.NUM(NUM_DREG)) u_dec (
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .bank_sel (bank_sel),
        .lane     (lane),
        .sel      (sel)
    );

    ramdac_palette #(.DEPTH(PAL_DEPTH)) u_pal (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (sel[DR_PAL_WIDX]),
        .wr_comp  (sel[DR_PAL_DATA]),
        .din      (wr_data),
        .rd_idx   (pal_rd_idx),
        .rd_rgb   (pal_rd_rgb),
        .phase    (pal_phase)
    );

    ramdac_index_file #(.DEPTH(FILE_DEPTH)) u_ifile (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (sel[DR_IDX_LO]),
        .ld_hi    (sel[DR_IDX_HI]),
        .st_data  (sel[DR_IDX_DATA]),
        .din      (wr_data),
        .ev_wr    (ev_wr),
        .ev_addr  (ev_addr),
        .ev_val   (ev_val),
        .pll_src  (pll_src),
        .pll_f0   (pll_f0),
        .pll_f1n  (pll_f1n)
    );

    ramdac_mode_decode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_wr       (ev_wr),
        .ev_addr     (ev_addr),
        .ev_val      (ev_val),
        .pll_src     (pll_src),
        .pll_f0      (pll_f0),
        .pll_f1n     (pll_f1n),
        .pll_ok      (pll_ok),
        .pll_src_err (pll_src_err),
        .pll_m       (pll_m),
        .pll_vco_div (pll_vco_div),
        .pll_ref_div (pll_ref_div),
        .fmt_ok      (disp_en),
        .fmt_bad     (fmt_bad)
    );

    // Pixel mask register
    always_ff @(posedge clk) begin
        if (!rst_n) pix_mask <= MASK_FULL;
        else if (sel[DR_PIX_MASK]) pix_mask <= wr_data;
    end

    // Flag any mask narrower than all-ones
    always_comb mask_partial = (pix_mask != MASK_FULL);

endmodule

// File: rtl/ramdac_regport_chk.sv
// ramdac_regport_chk: temporal checks on the register port, bound to the top.
module ramdac_regport_chk #(
    parameter int unsigned PAL_IW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_byte,
    input logic [PAL_IW-1:0] pal_rd_idx,
    input logic [23:0]       pal_rd_rgb,
    input logic [1:0]        pal_phase,
    input logic              pll_ok,
    input logic              pll_src_err,
    input logic [3:0]        pll_m,
    input logic [7:0]        pll_vco_div,
    input logic [7:0]        pll_ref_div,
    input logic              disp_en,
    input logic              fmt_bad,
    input logic              mask_partial
);
    // R1: a wide access leaves every visible result alone
    assert_wide_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte) |=> ($stable(mask_partial) && $stable(disp_en) &&
            $stable(fmt_bad) && $stable(pll_ok) && $stable(pll_src_err) &&
            (!$stable(pal_rd_idx) || $stable(pal_rd_rgb))));

    // R4: the component counter never leaves red/green/blue
    assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pal_phase != 2'd3);

    // R7: a good start and a source error never coexist
    assert_pll_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_ok && pll_src_err));

    // R8: latched divider set stays inside its legal ranges
    assert_pll_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ok |-> ($onehot(pll_m) && (pll_vco_div >= 8'd65) &&
            (pll_vco_div <= 8'd128) && ((pll_ref_div % {4'd0, pll_m}) == 8'd0)));

    // R9: display enable and unsupported format are exclusive
    assert_fmt_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_en && fmt_bad));

endmodule

bind ramdac_regport ramdac_regport_chk #(.PAL_IW(PAL_IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_byte      (wr_byte),
    .pal_rd_idx   (pal_rd_idx),
    .pal_rd_rgb   (pal_rd_rgb),
    .pal_phase    (pal_phase),
    .pll_ok       (pll_ok),
    .pll_src_err  (pll_src_err),
    .pll_m        (pll_m),
    .pll_vco_div  (pll_vco_div),
    .pll_ref_div  (pll_ref_div),
    .disp_en      (disp_en),
    .fmt_bad      (fmt_bad),
    .mask_partial (mask_partial)
);

// File: tb/tb_ramdac_regport.sv
// tb_ramdac_regport: vector walk over the palette path, then directed tests.
module tb_ramdac_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_byte = 1'b0;
    logic        bank_sel = 1'b0;
    logic [1:0]  lane = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  pal_rd_idx = 8'd0;
    logic [23:0] pal_rd_rgb;
    logic        pll_ok, pll_src_err, disp_en, fmt_bad, mask_partial;
    logic [3:0]  pll_m;
    logic [7:0]  pll_vco_div, pll_ref_div;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ramdac_regport dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .bank_sel(bank_sel), .lane(lane), .wr_data(wr_data),
        .pal_rd_idx(pal_rd_idx), .pal_rd_rgb(pal_rd_rgb),
        .pll_ok(pll_ok), .pll_src_err(pll_src_err), .pll_m(pll_m),
        .pll_vco_div(pll_vco_div), .pll_ref_div(pll_ref_div),
        .disp_en(disp_en), .fmt_bad(fmt_bad), .mask_partial(mask_partial)
    );

    // Fields: [47:44] req, [43] bank, [42:41] lane, [40] byte, [39:32] data,
    // [31:24] read index, [23:0] expected palette entry after the write
    localparam int NV = 18;
    localparam logic [47:0] VEC [NV] = '{
        {4'd3, 1'b0, 2'd0, 1'b1, 8'h05, 8'h05, 24'h000000}, // R3 load index 5
        {4'd4, 1'b0, 2'd1, 1'b1, 8'h11, 8'h05, 24'h000000}, // R4 red
        {4'd4, 1'b0, 2'd1, 1'b1, 8'h22, 8'h05, 24'h000000}, // R4 green
        {4'd4, 1'b0, 2'd1, 1'b1, 8'h33, 8'h05, 24'h112233}, // R4 blue commits
        {4'd4, 1'b0, 2'd1, 1'b1, 8'h44, 8'h06, 24'h000000}, // R4 next index
        {4'd4, 1'b0, 2'd1, 1'b1, 8'h55, 8'h06, 24'h000000},
        {4'd4, 1'b0, 2'd1, 1'b1, 8'h66, 8'h06, 24'h445566},
        {4'd1, 1'b0, 2'd1, 1'b0, 8'h99, 8'h07, 24'h000000}, // R1 wide ignored
        {4'd1, 1'b0, 2'd1, 1'b1, 8'hAA, 8'h07, 24'h000000},
        {4'd1, 1'b0, 2'd1, 1'b1, 8'hBB, 8'h07, 24'h000000},
        {4'd3, 1'b0, 2'd0, 1'b1, 8'h08, 8'h07, 24'h000000}, // R3 abandon triple
        {4'd3, 1'b0, 2'd1, 1'b1, 8'h01, 8'h08, 24'h000000},
        {4'd3, 1'b0, 2'd1, 1'b1, 8'h02, 8'h08, 24'h000000},
        {4'd3, 1'b0, 2'd1, 1'b1, 8'h03, 8'h08, 24'h010203},
        {4'd2, 1'b1, 2'd0, 1'b1, 8'h77, 8'h77, 24'h000000}, // R2 bank 1 lane 0
        {4'd2, 1'b0, 2'd1, 1'b1, 8'hCC, 8'h09, 24'h000000},
        {4'd2, 1'b0, 2'd1, 1'b1, 8'hDD, 8'h09, 24'h000000},
        {4'd2, 1'b0, 2'd1, 1'b1, 8'hEE, 8'h09, 24'hCCDDEE}
    };

    task automatic put(input logic b, input logic [1:0] l, input logic byt,
                       input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; bank_sel = b; lane = l; wr_byte = byt; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_byte = 1'b0;
        #1;
    endtask

    task automatic ind_write(input logic [15:0] a, input logic [7:0] d);
        put(1'b1, 2'd0, 1'b1, a[7:0]);
        put(1'b1, 2'd1, 1'b1, a[15:8]);
        put(1'b1, 2'd2, 1'b1, d);
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [7:0] idx,
                            input logic [23:0] exp);
        pal_rd_idx = idx;
        #1;
        check(tag, 32'(pal_rd_rgb), 32'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        rd_check("R11 palette entry 0", 8'h00, 24'h0);
        rd_check("R11 palette entry 255", 8'hFF, 24'h0);
        check("R11 mask_partial", 32'(mask_partial), 0);
        check("R11 pll_ok", 32'(pll_ok), 0);
        check("R11 pll_src_err", 32'(pll_src_err), 0);
        check("R11 disp_en", 32'(disp_en), 0);
        check("R11 fmt_bad", 32'(fmt_bad), 0);

        // Vector walk over the palette path
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][43], VEC[i][42:41], VEC[i][40], VEC[i][39:32]);
            pal_rd_idx = VEC[i][31:24];
            #1;
            total++;
            if (pal_rd_rgb !== VEC[i][23:0]) begin
                bad++;
                $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                         VEC[i][47:44], i, pal_rd_rgb, VEC[i][23:0]);
            end
        end
        rd_check("R2 no palette load from index-low write", 8'h77, 24'h0);

        // R5 wrap from 255 to 0
        put(1'b0, 2'd0, 1'b1, 8'hFF);
        put(1'b0, 2'd1, 1'b1, 8'h10);
        put(1'b0, 2'd1, 1'b1, 8'h20);
        put(1'b0, 2'd1, 1'b1, 8'h30);
        rd_check("R5 entry 255", 8'hFF, 24'h102030);
        put(1'b0, 2'd1, 1'b1, 8'h40);
        put(1'b0, 2'd1, 1'b1, 8'h50);
        put(1'b0, 2'd1, 1'b1, 8'h60);
        rd_check("R5 wrapped to entry 0", 8'h00, 24'h405060);

        // R10 mask flag, R1 wide write to the mask
        put(1'b0, 2'd2, 1'b1, 8'hF0);
        check("R10 partial mask flagged", 32'(mask_partial), 1);
        put(1'b0, 2'd2, 1'b0, 8'hFF);
        check("R1 wide mask write ignored", 32'(mask_partial), 1);
        put(1'b0, 2'd2, 1'b1, 8'hFF);
        check("R10 full mask clears flag", 32'(mask_partial), 0);
        put(1'b0, 2'd3, 1'b1, 8'h00);
        check("R2 register 3 no effect", 32'(mask_partial), 0);

        // R7 illegal PLL source
        ind_write(16'h0010, 8'h02);
        ind_write(16'h0020, 8'h4A);
        ind_write(16'h0021, 8'h05);
        ind_write(16'h0002, 8'h01);
        check("R7 bad source error", 32'(pll_src_err), 1);
        check("R7 bad source not ok", 32'(pll_ok), 0);

        // R7/R8 legal source: m=4, vco=10+65, ref=5*4
        ind_write(16'h0010, 8'h01);
        ind_write(16'h0002, 8'h01);
        check("R7 good source ok", 32'(pll_ok), 1);
        check("R7 good source clears error", 32'(pll_src_err), 0);
        check("R8 prescale", 32'(pll_m), 4);
        check("R8 vco divider", 32'(pll_vco_div), 75);
        check("R8 reference divider", 32'(pll_ref_div), 20);

        // R8 extremes: m=1, vco=128, ref=31; start bit clear first
        ind_write(16'h0020, 8'hFF);
        ind_write(16'h0021, 8'h1F);
        ind_write(16'h0002, 8'h00);
        check("R7 start bit clear keeps vco", 32'(pll_vco_div), 75);
        ind_write(16'h0002, 8'h01);
        check("R8 prescale m=1", 32'(pll_m), 1);
        check("R8 vco max", 32'(pll_vco_div), 128);
        check("R8 ref m=1", 32'(pll_ref_div), 31);
        ind_write(16'h0020, 8'h00);
        ind_write(16'h0021, 8'h03);
        ind_write(16'h0002, 8'h01);
        check("R8 prescale m=8", 32'(pll_m), 8);
        check("R8 ref m=8", 32'(pll_ref_div), 24);

        // R9 pixel format, R6 out-of-range drop
        ind_write(16'h000A, 8'h03);
        check("R9 format 3 enables display", 32'(disp_en), 1);
        check("R9 format 3 not bad", 32'(fmt_bad), 0);
        ind_write(16'h010A, 8'h02);
        check("R6 out-of-range write dropped", 32'(disp_en), 1);
        ind_write(16'h000A, 8'h02);
        check("R9 format 2 disables", 32'(disp_en), 0);
        check("R9 format 2 flagged", 32'(fmt_bad), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule